// File: doc/BRIEF.md
# SPI EEPROM Page-Write Controller

This block is the write path of a serial EEPROM slave. It watches the SPI pins with an over-sampling system clock and decodes a page-write command. After chip select falls, the block collects an 8-bit opcode, a 16-bit address (high byte first) and any number of data bytes. The data bytes land in a 32-entry page buffer. When chip select rises exactly on a data-byte boundary and every acceptance condition holds, a self-timed write cycle starts. During that cycle the buffered bytes go to the memory array as a stream of write requests.

The write-enable latch and the block-protect selector come in as plain status inputs. The block raises `busy` for the whole write cycle. It pulses `wen_clear` to tell the status logic to drop the write-enable latch. The array side is a valid/ready stream. Once `mem_wr_valid` is high, the address and data stay unchanged until `mem_wr_ready` accepts them. The array may hold `mem_wr_ready` low for any length of time, and the write cycle then stretches until the last request has been taken. Any other opcode makes the block ignore the rest of that chip-select window.

Top module: `spw_page_writer`

## Requirements
- R1: After reset, `busy`, `mem_wr_valid` and `wen_clear` are all 0.
- R2: Bits are sampled on rising `spi_sclk` while `spi_cs_n` is low, MSB first. Opcode 8'h02 selects a page write. The next two bytes form a 16-bit address, high byte first. Only address bits [9:0] are used; bits [15:10] are ignored. Bits [9:5] select the page and bits [4:0] the starting offset. A committed byte is written to array address {page, offset}.
- R3: Consecutive data bytes in one chip-select window go to consecutive offsets within the page, and all of them are written in one write cycle.
- R4: The offset wraps from 31 to 0 within the same page. A later byte at an offset replaces the earlier one, and only the latest value is written.
- R5: If `wr_en_latched` is 0 when the opcode completes, the command is dropped. There are no requests, `busy` does not rise and `wen_clear` does not pulse.
- R6: A page-write command that starts while `busy` is 1 is dropped. It adds no requests and no `wen_clear` pulse, and it does not disturb the cycle that is running.
- R7: If chip select rises with a partial data byte shifted in (bit count not a multiple of 8), nothing is written and `wen_clear` pulses once.
- R8: `prot_sel` encodes the protected region: 0 protects nothing, 1 protects addresses 0x300-0x3FF, 2 protects 0x200-0x3FF, and 3 protects everything. A command aimed at a protected address writes nothing and pulses `wen_clear` once.
- R9: An accepted write holds `busy` high for exactly TWC clocks if all its requests are accepted within that time, and otherwise until the last request is accepted. `wen_clear` pulses for one clock in the cycle in which `busy` falls.
- R10: Requests leave in ascending offset order, one for each offset that was written. While `mem_wr_valid` is high and `mem_wr_ready` is low, the address and data hold steady.
- R11: A window whose opcode is not 8'h02 causes no requests, no `busy` and no `wen_clear`.
- R12: If chip select rises after the address but before any complete data byte, nothing is written and `wen_clear` pulses once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, over-samples the SPI pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sclk | input | 1 | SPI serial clock |
| spi_cs_n | input | 1 | SPI chip select, active low |
| spi_mosi | input | 1 | SPI serial data into the device |
| wr_en_latched | input | 1 | Write-enable latch state from the status logic |
| prot_sel | input | 2 | Block-protect selector |
| mem_wr_valid | output | 1 | Array write request valid |
| mem_wr_ready | input | 1 | Array accepts the request this clock |
| mem_wr_addr | output | 10 | Array write address |
| mem_wr_data | output | 8 | Array write data |
| busy | output | 1 | Write cycle in progress |
| wen_clear | output | 1 | One-clock request to clear the write-enable latch |

## Verification
The write-cycle timer reaching zero and the last array request being accepted are independent events, so they can fall in the same cycle or in either order. The bench produces both orders. With `mem_wr_ready` held high, the drain ends long before the timer, and `busy` must last exactly TWC clocks. With `mem_wr_ready` held low well beyond TWC, the timer expires first. The bench then checks that `busy` stretches past TWC, that every queued byte still arrives in order, and that `wen_clear` comes only once, with the falling edge of `busy`.

// File: rtl/spw_pkg.sv
package spw_pkg;
  localparam int          DW       = 8;
  localparam logic [7:0]  OP_WRITE = 8'h02;

  typedef enum logic [2:0] {
    PS_IDLE,
    PS_OPC,
    PS_ADDR_HI,
    PS_ADDR_LO,
    PS_DATA,
    PS_PROT
  } parse_st_t;
endpackage

// File: rtl/spw_spi_sampler.sv
// Brings the SPI pins into the clk domain, frames bytes and reports
// chip-select edges together with the bit alignment at the rising edge.
module spw_spi_sampler #(
  parameter int SYNC_STAGES = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   spi_sclk,
  input  logic                   spi_cs_n,
  input  logic                   spi_mosi,
  output logic                   byte_vld,
  output logic [spw_pkg::DW-1:0] byte_val,
  output logic                   cs_fall,
  output logic                   cs_rise,
  output logic                   cs_aligned
);
  import spw_pkg::*;
  localparam int BW = $clog2(DW);

  logic [SYNC_STAGES-1:0] sclk_q, cs_q, mosi_q;
  logic                   sclk_d, cs_d;
  logic [DW-2:0]          shreg;
  logic [BW-1:0]          bcnt;
  logic                   sclk_s, cs_s, mosi_s;

  assign sclk_s = sclk_q[SYNC_STAGES-1];
  assign cs_s   = cs_q[SYNC_STAGES-1];
  assign mosi_s = mosi_q[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q     <= '0;
      cs_q       <= '1;
      mosi_q     <= '0;
      sclk_d     <= 1'b0;
      cs_d       <= 1'b1;
      shreg      <= '0;
      bcnt       <= '0;
      byte_vld   <= 1'b0;
      byte_val   <= '0;
      cs_fall    <= 1'b0;
      cs_rise    <= 1'b0;
      cs_aligned <= 1'b0;
    end else begin
      sclk_q     <= {sclk_q[SYNC_STAGES-2:0], spi_sclk};
      cs_q       <= {cs_q[SYNC_STAGES-2:0], spi_cs_n};
      mosi_q     <= {mosi_q[SYNC_STAGES-2:0], spi_mosi};
      sclk_d     <= sclk_s;
      cs_d       <= cs_s;
      byte_vld   <= 1'b0;
      cs_fall    <= !cs_s && cs_d;
      cs_rise    <= cs_s && !cs_d;
      cs_aligned <= (bcnt == '0);
      if (!cs_s && cs_d) begin
        bcnt <= '0;
      end else if (!cs_s && sclk_s && !sclk_d) begin
        shreg <= {shreg[DW-3:0], mosi_s};
        bcnt  <= bcnt + 1'b1;
        if (bcnt == BW'(DW-1)) begin
          byte_vld <= 1'b1;
          byte_val <= {shreg, mosi_s};
        end
      end
    end
  end
endmodule

// File: rtl/spw_parser.sv
// Command decoder and page buffer.
module spw_parser #(
  parameter int AW         = 10,
  parameter int PAGE_BYTES = 32
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          byte_vld,
  input  logic [spw_pkg::DW-1:0]        byte_val,
  input  logic                          cs_fall,
  input  logic                          cs_rise,
  input  logic                          cs_aligned,
  input  logic                          wen_latched,
  input  logic [1:0]                    prot_sel,
  input  logic                          cyc_busy,
  input  logic [$clog2(PAGE_BYTES)-1:0] rd_idx,
  output logic [spw_pkg::DW-1:0]        rd_data,
  output logic                          rd_mask,
  output logic [AW-$clog2(PAGE_BYTES)-1:0] page,
  output logic                          commit,
  output logic                          reject
);
  import spw_pkg::*;
  localparam int PW = $clog2(PAGE_BYTES);
  localparam int HW = AW - DW;

  parse_st_t             st;
  logic [HW-1:0]         addr_hi;
  logic [PW-1:0]         off;
  logic                  have_data;
  logic [DW-1:0]         pbuf [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] pmask;
  logic [AW-1:0]         full_addr;
  logic                  in_prot, op_accept, wr_en;

  assign full_addr = {addr_hi, byte_val};
  assign op_accept = byte_vld && !cs_fall && !cs_rise && (st == PS_OPC) &&
                     (byte_val == OP_WRITE) && wen_latched && !cyc_busy;
  assign wr_en     = byte_vld && !cs_fall && !cs_rise && (st == PS_DATA);

  always_comb begin
    unique case (prot_sel)
      2'd0:    in_prot = 1'b0;
      2'd1:    in_prot = (full_addr[AW-1 -: 2] == 2'b11);
      2'd2:    in_prot = full_addr[AW-1];
      default: in_prot = 1'b1;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= PS_IDLE;
      addr_hi   <= '0;
      page      <= '0;
      off       <= '0;
      have_data <= 1'b0;
      commit    <= 1'b0;
      reject    <= 1'b0;
    end else begin
      commit <= 1'b0;
      reject <= 1'b0;
      if (cs_fall) begin
        st <= PS_OPC;
      end else if (cs_rise) begin
        st <= PS_IDLE;
        unique case (st)
          PS_DATA: begin
            if (cs_aligned && have_data) commit <= 1'b1;
            else                         reject <= 1'b1;
          end
          PS_ADDR_HI, PS_ADDR_LO, PS_PROT: reject <= 1'b1;
          default: ;
        endcase
      end else if (byte_vld) begin
        unique case (st)
          PS_OPC:     st <= op_accept ? PS_ADDR_HI : PS_IDLE;
          PS_ADDR_HI: begin
            addr_hi <= byte_val[HW-1:0];
            st      <= PS_ADDR_LO;
          end
          PS_ADDR_LO: begin
            page      <= full_addr[AW-1:PW];
            off       <= full_addr[PW-1:0];
            have_data <= 1'b0;
            st        <= in_prot ? PS_PROT : PS_DATA;
          end
          PS_DATA: begin
            off       <= off + 1'b1;
            have_data <= 1'b1;
          end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pmask <= '0;
      for (int i = 0; i < PAGE_BYTES; i++) pbuf[i] <= '0;
    end else if (op_accept) begin
      pmask <= '0;
    end else if (wr_en) begin
      pbuf[off]  <= byte_val;
      pmask[off] <= 1'b1;
    end
  end

  assign rd_data = pbuf[rd_idx];
  assign rd_mask = pmask[rd_idx];
endmodule

// File: rtl/spw_commit.sv
// Write-cycle timer and drain of the page buffer to the array stream.
module spw_commit #(
  parameter int AW         = 10,
  parameter int PAGE_BYTES = 32,
  parameter int TWC        = 1000
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             start,
  input  logic [AW-$clog2(PAGE_BYTES)-1:0] page,
  output logic [$clog2(PAGE_BYTES)-1:0]    rd_idx,
  input  logic [spw_pkg::DW-1:0]           rd_data,
  input  logic                             rd_mask,
  output logic                             mem_wr_valid,
  input  logic                             mem_wr_ready,
  output logic [AW-1:0]                    mem_wr_addr,
  output logic [spw_pkg::DW-1:0]           mem_wr_data,
  output logic                             busy,
  output logic                             done
);
  localparam int PW = $clog2(PAGE_BYTES);
  localparam int TW = $clog2(TWC + 1);

  logic [PW:0]   ptr;
  logic [TW-1:0] tcnt;
  logic          drained;

  assign drained      = ptr[PW];
  assign rd_idx       = ptr[PW-1:0];
  assign mem_wr_valid = busy && !drained && rd_mask;
  assign mem_wr_addr  = {page, ptr[PW-1:0]};
  assign mem_wr_data  = rd_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      done <= 1'b0;
      ptr  <= '0;
      tcnt <= '0;
    end else begin
      done <= 1'b0;
      if (start && !busy) begin
        busy <= 1'b1;
        ptr  <= '0;
        tcnt <= TW'(TWC - 1);
      end else if (busy) begin
        if (!drained && (!rd_mask || mem_wr_ready)) ptr <= ptr + 1'b1;
        if (tcnt != '0) begin
          tcnt <= tcnt - 1'b1;
        end else if (drained) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/spw_page_writer.sv
module spw_page_writer #(
  parameter int AW          = 10,
  parameter int PAGE_BYTES  = 32,
  parameter int TWC         = 1000,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          spi_sclk,
  input  logic          spi_cs_n,
  input  logic          spi_mosi,
  input  logic          wr_en_latched,
  input  logic [1:0]    prot_sel,
  output logic          mem_wr_valid,
  input  logic          mem_wr_ready,
  output logic [AW-1:0] mem_wr_addr,
  output logic [7:0]    mem_wr_data,
  output logic          busy,
  output logic          wen_clear
);
  import spw_pkg::*;
  localparam int PW = $clog2(PAGE_BYTES);

  logic          byte_vld, cs_fall, cs_rise, cs_aligned;
  logic [DW-1:0] byte_val, rd_data;
  logic [PW-1:0] rd_idx;
  logic          rd_mask, commit, reject, done;
  logic [AW-PW-1:0] page;

  spw_spi_sampler #(.SYNC_STAGES(SYNC_STAGES)) u_sampler (
    .clk, .rst_n, .spi_sclk, .spi_cs_n, .spi_mosi,
    .byte_vld, .byte_val, .cs_fall, .cs_rise, .cs_aligned
  );

  spw_parser #(.AW(AW), .PAGE_BYTES(PAGE_BYTES)) u_parser (
    .clk, .rst_n, .byte_vld, .byte_val, .cs_fall, .cs_rise, .cs_aligned,
    .wen_latched(wr_en_latched), .prot_sel, .cyc_busy(busy),
    .rd_idx, .rd_data, .rd_mask, .page, .commit, .reject
  );

  spw_commit #(.AW(AW), .PAGE_BYTES(PAGE_BYTES), .TWC(TWC)) u_commit (
    .clk, .rst_n, .start(commit), .page, .rd_idx, .rd_data, .rd_mask,
    .mem_wr_valid, .mem_wr_ready, .mem_wr_addr, .mem_wr_data, .busy, .done
  );

  assign wen_clear = done | reject;
endmodule

// File: rtl/spw_checker.sv
module spw_checker #(
  parameter int AW  = 10,
  parameter int TWC = 1000
) (
  input logic          clk,
  input logic          rst_n,
  input logic          mem_wr_valid,
  input logic          mem_wr_ready,
  input logic [AW-1:0] mem_wr_addr,
  input logic [7:0]    mem_wr_data,
  input logic          busy,
  input logic          wen_clear
);
  logic [31:0] busy_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    busy_run <= '0;
    else if (busy) busy_run <= busy_run + 1'b1;
    else           busy_run <= '0;
  end

  // R10: a stalled request keeps its payload
  a_r10_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_valid && !mem_wr_ready |=> mem_wr_valid && $stable(mem_wr_addr) && $stable(mem_wr_data));

  // R9: requests only inside a write cycle
  a_r9_valid_in_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_valid |-> busy);

  // R9: the cycle never ends before the timer length
  a_r9_min_length: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (busy_run >= 32'(TWC)));

  // R9: the latch clear comes with the end of the cycle
  a_r9_clear_on_end: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> wen_clear);
endmodule

bind spw_page_writer spw_checker #(.AW(AW), .TWC(TWC)) u_spw_checker (
  .clk(clk), .rst_n(rst_n), .mem_wr_valid(mem_wr_valid), .mem_wr_ready(mem_wr_ready),
  .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data), .busy(busy), .wen_clear(wen_clear)
);

// File: tb/test_spw_page_writer.sv
`timescale 1ns/1ps
module test_spw_page_writer;
  localparam int TWC_T = 400;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       spi_sclk = 1'b0, spi_cs_n = 1'b1, spi_mosi = 1'b0;
  logic       wr_en_latched = 1'b1;
  logic [1:0] prot_sel = 2'd0;
  logic       mem_wr_valid, mem_wr_ready, busy, wen_clear;
  logic [9:0] mem_wr_addr;
  logic [7:0] mem_wr_data;

  int checks = 0, errors = 0;
  int run_len = 0, last_len = 0, busy_rises = 0, clr_cnt = 0;
  int rdy_hold = 0;
  bit rdy_toggle = 1'b0, busy_prev = 1'b0, done_flag = 1'b0;
  logic [15:0] lfsr = 16'hACE1;
  logic [17:0] sb_q [$];
  logic [17:0] sb_e;

  always #5 clk = ~clk;

  spw_page_writer #(.TWC(TWC_T)) i_spw_page_writer (
    .clk, .rst_n, .spi_sclk, .spi_cs_n, .spi_mosi, .wr_en_latched, .prot_sel,
    .mem_wr_valid, .mem_wr_ready, .mem_wr_addr, .mem_wr_data, .busy, .wen_clear
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic summary();
    if (!done_flag) begin
      done_flag = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  // ready driver
  initial begin
    mem_wr_ready = 1'b1;
    forever begin
      @(posedge clk); #1;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      if (rdy_hold > 0) begin mem_wr_ready = 1'b0; rdy_hold--; end
      else mem_wr_ready = rdy_toggle ? lfsr[0] : 1'b1;
    end
  end

  // scoreboard monitor (R2, R3, R4, R10)
  always @(negedge clk) begin
    if (rst_n && mem_wr_valid && mem_wr_ready) begin
      if (sb_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R10 unexpected request: actual %h/%h expected none", mem_wr_addr, mem_wr_data);
      end else begin
        sb_e = sb_q.pop_front();
        chk({mem_wr_addr, mem_wr_data} === sb_e, "R10", "request {addr,data}",
            longint'({mem_wr_addr, mem_wr_data}), longint'(sb_e));
      end
    end
  end

  // busy / clear monitor
  always @(negedge clk) begin
    if (busy) run_len++;
    else if (run_len != 0) begin last_len = run_len; run_len = 0; end
    if (busy && !busy_prev) busy_rises++;
    busy_prev = busy;
    if (rst_n && wen_clear) clr_cnt++;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  function automatic bit prot_model(input logic [1:0] p, input logic [9:0] a);
    case (p)
      2'd0: return 1'b0;
      2'd1: return a >= 10'h300;
      2'd2: return a >= 10'h200;
      default: return 1'b1;
    endcase
  endfunction

  task automatic send_bit(input logic b);
    @(negedge clk) spi_mosi = b;
    repeat (4) @(negedge clk);
    spi_sclk = 1'b1;
    repeat (4) @(negedge clk);
    spi_sclk = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] b);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
  endtask

  task automatic xfer(input logic [7:0] op, input logic [15:0] a, input int n,
                      input int extra, input logic [7:0] seed, input bit busy_now,
                      output bit exp_commit, output int exp_clr);
    logic [7:0] m [32];
    bit         v [32];
    logic [4:0] off;
    bit         opened;
    opened     = (op == 8'h02) && wr_en_latched && !busy_now;
    exp_commit = opened && (n > 0) && (extra == 0) && !prot_model(prot_sel, a[9:0]);
    exp_clr    = opened ? 1 : 0;
    if (exp_commit) begin
      for (int i = 0; i < 32; i++) v[i] = 1'b0;
      off = a[4:0];
      for (int i = 0; i < n; i++) begin
        m[off] = seed + 8'(i * 13); v[off] = 1'b1; off = off + 1'b1;
      end
      for (int o = 0; o < 32; o++) if (v[o]) sb_q.push_back({a[9:5], 5'(o), m[o]});
    end
    @(negedge clk) spi_cs_n = 1'b0;
    repeat (4) @(negedge clk);
    send_byte(op);
    send_byte(a[15:8]);
    send_byte(a[7:0]);
    for (int i = 0; i < n; i++) send_byte(seed + 8'(i * 13));
    for (int i = 0; i < extra; i++) send_bit(1'b1);
    repeat (4) @(negedge clk);
    spi_cs_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic settle(input string tag, input bit ec, input int ecl,
                        input bit stalled, input int clr0, input int rises0);
    repeat (20) @(negedge clk);
    while (busy) @(negedge clk);
    repeat (2) @(negedge clk);
    chk(sb_q.size() == 0, tag, "pending requests", sb_q.size(), 0);
    chk(clr_cnt - clr0 == ecl, tag, "latch clears", clr_cnt - clr0, ecl);
    chk(busy_rises - rises0 == (ec ? 1 : 0), tag, "write cycles", busy_rises - rises0, ec ? 1 : 0);
    if (ec && !stalled) chk(last_len == TWC_T, "R9", "busy length", last_len, TWC_T);
    if (ec && stalled)  chk(last_len > TWC_T, "R9", "stretched busy length", last_len, TWC_T + 1);
  endtask

  task automatic run(input string tag, input logic [7:0] op, input logic [15:0] a,
                     input int n, input int extra, input logic [7:0] seed, input bit stalled);
    int c0, r0, ecl; bit ec;
    c0 = clr_cnt; r0 = busy_rises;
    xfer(op, a, n, extra, seed, 1'b0, ec, ecl);
    settle(tag, ec, ecl, stalled, c0, r0);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy == 1'b0, "R1", "busy after reset", busy, 0);
    chk(mem_wr_valid == 1'b0, "R1", "valid after reset", mem_wr_valid, 0);
    chk(wen_clear == 1'b0, "R1", "clear after reset", wen_clear, 0);

    run("R2", 8'h02, 16'h0005, 1, 0, 8'h5A, 1'b0);        // single byte
    run("R2", 8'h02, 16'hFC21, 2, 0, 8'h11, 1'b0);        // upper bits ignored
    run("R3", 8'h02, 16'h0103, 3, 0, 8'h30, 1'b0);        // sequential
    run("R4", 8'h02, 16'h00BE, 5, 0, 8'h70, 1'b0);        // wrap 30,31,0,1,2
    run("R4", 8'h02, 16'h0040, 34, 0, 8'h01, 1'b0);       // overwrite offsets 0,1
    wr_en_latched = 1'b0;
    run("R5", 8'h02, 16'h0010, 2, 0, 8'h22, 1'b0);        // latch not set
    wr_en_latched = 1'b1;
    run("R7", 8'h02, 16'h0020, 1, 3, 8'h44, 1'b0);        // partial byte
    run("R12", 8'h02, 16'h0030, 0, 0, 8'h00, 1'b0);       // no data byte
    prot_sel = 2'd1;
    run("R8", 8'h02, 16'h0300, 1, 0, 8'h66, 1'b0);        // upper quarter
    run("R8", 8'h02, 16'h02FF, 1, 0, 8'h67, 1'b0);        // just below it
    prot_sel = 2'd2;
    run("R8", 8'h02, 16'h0200, 1, 0, 8'h68, 1'b0);        // upper half
    prot_sel = 2'd3;
    run("R8", 8'h02, 16'h0000, 1, 0, 8'h69, 1'b0);        // whole array
    prot_sel = 2'd0;
    run("R11", 8'h03, 16'h0050, 2, 0, 8'h77, 1'b0);       // other opcode

    begin : r6_overlap
      int c0, r0, l1, l2; bit e1, e2;
      c0 = clr_cnt; r0 = busy_rises;
      xfer(8'h02, 16'h0060, 2, 0, 8'h90, 1'b0, e1, l1);
      xfer(8'h02, 16'h0080, 2, 0, 8'hA0, 1'b1, e2, l2);  // during busy
      settle("R6", e1, l1 + l2, 1'b0, c0, r0);
    end

    rdy_toggle = 1'b1;
    run("R10", 8'h02, 16'h01C4, 10, 0, 8'h0F, 1'b0);      // jittery ready
    rdy_toggle = 1'b0;
    rdy_hold = 900;
    run("R10", 8'h02, 16'h0287, 2, 0, 8'hC3, 1'b1);       // stall past timer

    summary();
  end
endmodule